// File: doc/BRIEF.md
# Combined Read/Write Outstanding Transaction Limiter

This block is placed on an AXI4 link between a single master and a single slave. It limits how many transactions may be in flight at once. There are three caps: one for reads, one for writes, and one for reads and writes counted together. With the default setting of one for each cap, the link carries exactly one transaction at a time. A pending read therefore holds off every new write address, and a pending write holds off every new read address. A limiter that counted the two directions separately would let one read and one write overlap, and this block rules that out.

Only the two address channels are gated. An accepted address is kept in a one-entry register stage and presented to the slave from there. The read data, write data and write response channels are wired straight through, and the block only watches them to detect when a transaction finishes. If a read address and a write address arrive in the same cycle and only one slot remains, the read is taken.

Top module: `axi_txn_gate`

## Requirements
- R1: While reset is high and on the first cycle after it falls, all pending counts are zero and neither slave-side address VALID is asserted. From the first cycle after reset, both master-side address READY outputs are high.
- R2: The number of reads accepted from the master and not yet finished never exceeds RD_LIMIT (default 1).
- R3: The number of writes accepted from the master and not yet finished never exceeds WR_LIMIT (default 1).
- R4: Reads plus writes pending together never exceed TOT_LIMIT (default 1). While the combined count is at the cap, `s_arready` and `s_awready` are both low.
- R5: In a cycle where `s_arvalid` and `s_awvalid` are both high and the read can be accepted, the write is refused if accepting both would pass the combined cap. With the defaults, the write waits until the read has finished.
- R6: A read finishes only on an R handshake (`m_rvalid` and `s_rready`) with `m_rlast` = 1. Beats with `m_rlast` = 0 free nothing. In the cycle after the last beat, `s_arready` is high again.
- R7: A write finishes on a B handshake (`m_bvalid` and `s_bready`). W beats free nothing. In the cycle after the B handshake, `s_awready` is high unless `s_arvalid` is high in that same cycle.
- R8: An address accepted from the master appears on the slave side with the same id, address and length, starting the cycle after acceptance. Once asserted, `m_arvalid`/`m_awvalid` and their fields stay unchanged until the slave's READY is seen.
- R9: The R, W and B channels pass through unchanged in both directions within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_arvalid | input | 1 | Read address valid from master |
| s_arready | output | 1 | Read address ready to master (gated) |
| s_arid | input | ID_W | Read id from master |
| s_araddr | input | ADDR_W | Read address from master |
| s_arlen | input | LEN_W | Read burst length minus one |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Read data ready from master |
| s_rid | output | ID_W | Read data id to master |
| s_rdata | output | DATA_W | Read data to master |
| s_rresp | output | 2 | Read response to master |
| s_rlast | output | 1 | Last read beat to master |
| s_awvalid | input | 1 | Write address valid from master |
| s_awready | output | 1 | Write address ready to master (gated) |
| s_awid | input | ID_W | Write id from master |
| s_awaddr | input | ADDR_W | Write address from master |
| s_awlen | input | LEN_W | Write burst length minus one |
| s_wvalid | input | 1 | Write data valid from master |
| s_wready | output | 1 | Write data ready to master |
| s_wdata | input | DATA_W | Write data from master |
| s_wstrb | input | DATA_W/8 | Write byte strobes from master |
| s_wlast | input | 1 | Last write beat from master |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Write response ready from master |
| s_bid | output | ID_W | Write response id to master |
| s_bresp | output | 2 | Write response code to master |
| m_arvalid | output | 1 | Read address valid to slave (registered) |
| m_arready | input | 1 | Read address ready from slave |
| m_arid | output | ID_W | Read id to slave |
| m_araddr | output | ADDR_W | Read address to slave |
| m_arlen | output | LEN_W | Read burst length to slave |
| m_rvalid | input | 1 | Read data valid from slave |
| m_rready | output | 1 | Read data ready to slave |
| m_rid | input | ID_W | Read data id from slave |
| m_rdata | input | DATA_W | Read data from slave |
| m_rresp | input | 2 | Read response from slave |
| m_rlast | input | 1 | Last read beat from slave |
| m_awvalid | output | 1 | Write address valid to slave (registered) |
| m_awready | input | 1 | Write address ready from slave |
| m_awid | output | ID_W | Write id to slave |
| m_awaddr | output | ADDR_W | Write address to slave |
| m_awlen | output | LEN_W | Write burst length to slave |
| m_wvalid | output | 1 | Write data valid to slave |
| m_wready | input | 1 | Write data ready from slave |
| m_wdata | output | DATA_W | Write data to slave |
| m_wstrb | output | DATA_W/8 | Write byte strobes to slave |
| m_wlast | output | 1 | Last write beat to slave |
| m_bvalid | input | 1 | Write response valid from slave |
| m_bready | output | 1 | Write response ready to slave |
| m_bid | input | ID_W | Write response id from slave |
| m_bresp | input | 2 | Write response code from slave |

## Verification
The bench targets the cases where a limiter that counts each direction on its own slips through. In one case a read and a write are offered in the same cycle. In another, a write is offered while a long read burst is still returning. A design that checked only the per-direction caps would accept both, and the per-cycle occupancy check would see two pending transactions. Several cases probe when a transaction counts as finished. If a design frees the slot on the first R beat instead of the beat with `m_rlast`, it reopens address READY in the middle of a burst. If it frees a write on the W last beat, it reopens before the B response. If it misses the cycle where a completion and a request coincide, READY stays low after the transaction has finished, which the reopen checks catch. Random slave stalls keep `m_arvalid` waiting, so a design that withdrew or changed a slave-side address while it was waiting is caught by the hold check and the in-order address scoreboard.

// File: rtl/axi_gate_pkg.sv
package axi_gate_pkg;

  // Width of a counter that must hold values 0..limit.
  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Per-cycle decision on which master-side address channel is open.
  typedef struct packed {
    logic rd;
    logic wr;
  } gate_open_t;

endpackage

// File: rtl/gate_pend_cnt.sv
// Up/down counter of pending transactions. Up to two increments and two
// decrements can land in one cycle, and all of them are applied together.
module gate_pend_cnt #(
  parameter int CW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    up,
  input  logic [1:0]    dn,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(up) - CW'(dn);
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/gate_addr_slot.sv
// One-entry register stage for an address channel. It loads on an accepted
// master handshake and holds VALID and payload until the slave takes them.
module gate_addr_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         vld,
  output logic [W-1:0] dout,
  input  logic         take,
  output logic         free
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (load) begin
      vld_q <= 1'b1;
    end else if (take) begin
      vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dat_q <= din;
    end
  end

  assign vld  = vld_q;
  assign dout = dat_q;
  assign free = ~vld_q;

endmodule

// File: rtl/gate_issue_arb.sv
// Decides which address channel may accept this cycle. When only one
// combined slot is left and a read is being taken, the write is refused.
module gate_issue_arb
  import axi_gate_pkg::*;
(
  input  logic       ar_req,
  input  logic       ar_free,
  input  logic       aw_free,
  input  logic       rd_room,
  input  logic       wr_room,
  input  logic       tot_room,
  input  logic       tot_room2,
  output gate_open_t open
);

  logic ar_ok;
  logic ar_go;

  assign ar_ok   = ar_free & rd_room & tot_room;
  assign ar_go   = ar_req & ar_ok;
  assign open.rd = ar_ok;
  assign open.wr = aw_free & wr_room & (ar_go ? tot_room2 : tot_room);

endmodule

// File: rtl/axi_txn_gate.sv
module axi_txn_gate
  import axi_gate_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  parameter int RD_LIMIT  = 1,
  parameter int WR_LIMIT  = 1,
  parameter int TOT_LIMIT = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ID_W-1:0]     s_arid,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic [LEN_W-1:0]    s_arlen,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic [ID_W-1:0]     s_rid,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rlast,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ID_W-1:0]     s_awid,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic [LEN_W-1:0]    s_awlen,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [ID_W-1:0]     s_bid,
  output logic [1:0]          s_bresp,
  output logic                m_arvalid,
  input  logic                m_arready,
  output logic [ID_W-1:0]     m_arid,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [LEN_W-1:0]    m_arlen,
  input  logic                m_rvalid,
  output logic                m_rready,
  input  logic [ID_W-1:0]     m_rid,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ID_W-1:0]     m_awid,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [LEN_W-1:0]    m_awlen,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [ID_W-1:0]     m_bid,
  input  logic [1:0]          m_bresp
);

  localparam int RD_CW  = cnt_width(RD_LIMIT);
  localparam int WR_CW  = cnt_width(WR_LIMIT);
  localparam int TOT_CW = cnt_width(TOT_LIMIT);
  localparam int A_W    = ID_W + ADDR_W + LEN_W;

  logic [RD_CW-1:0]  rd_cnt;
  logic [WR_CW-1:0]  wr_cnt;
  logic [TOT_CW-1:0] tot_cnt;

  logic       rd_room, wr_room, tot_room, tot_room2;
  logic       ar_free, aw_free;
  logic       ar_hs, aw_hs, rd_done, wr_done;
  gate_open_t open;
  logic [A_W-1:0] ar_q, aw_q;

  // Room left under each cap, taken from registered counts only.
  assign rd_room   = rd_cnt  < RD_CW'(RD_LIMIT);
  assign wr_room   = wr_cnt  < WR_CW'(WR_LIMIT);
  assign tot_room  = tot_cnt < TOT_CW'(TOT_LIMIT);
  assign tot_room2 = tot_cnt < TOT_CW'(TOT_LIMIT - 1);

  gate_issue_arb u_arb (
    .ar_req    (s_arvalid),
    .ar_free   (ar_free),
    .aw_free   (aw_free),
    .rd_room   (rd_room),
    .wr_room   (wr_room),
    .tot_room  (tot_room),
    .tot_room2 (tot_room2),
    .open      (open)
  );

  assign s_arready = open.rd;
  assign s_awready = open.wr;
  assign ar_hs     = s_arvalid & s_arready;
  assign aw_hs     = s_awvalid & s_awready;

  // Completion events seen on the pass-through channels.
  assign rd_done = m_rvalid & s_rready & m_rlast;
  assign wr_done = m_bvalid & s_bready;

  gate_addr_slot #(.W(A_W)) u_ar_slot (
    .clk  (clk),
    .rst  (rst),
    .load (ar_hs),
    .din  ({s_arid, s_araddr, s_arlen}),
    .vld  (m_arvalid),
    .dout (ar_q),
    .take (m_arready),
    .free (ar_free)
  );

  gate_addr_slot #(.W(A_W)) u_aw_slot (
    .clk  (clk),
    .rst  (rst),
    .load (aw_hs),
    .din  ({s_awid, s_awaddr, s_awlen}),
    .vld  (m_awvalid),
    .dout (aw_q),
    .take (m_awready),
    .free (aw_free)
  );

  assign {m_arid, m_araddr, m_arlen} = ar_q;
  assign {m_awid, m_awaddr, m_awlen} = aw_q;

  gate_pend_cnt #(.CW(RD_CW)) u_rd_cnt (
    .clk (clk),
    .rst (rst),
    .up  ({1'b0, ar_hs}),
    .dn  ({1'b0, rd_done}),
    .cnt (rd_cnt)
  );

  gate_pend_cnt #(.CW(WR_CW)) u_wr_cnt (
    .clk (clk),
    .rst (rst),
    .up  ({1'b0, aw_hs}),
    .dn  ({1'b0, wr_done}),
    .cnt (wr_cnt)
  );

  gate_pend_cnt #(.CW(TOT_CW)) u_tot_cnt (
    .clk (clk),
    .rst (rst),
    .up  ({ar_hs & aw_hs, ar_hs ^ aw_hs}),
    .dn  ({rd_done & wr_done, rd_done ^ wr_done}),
    .cnt (tot_cnt)
  );

  // Pass-through channels.
  assign s_rvalid = m_rvalid;
  assign m_rready = s_rready;
  assign s_rid    = m_rid;
  assign s_rdata  = m_rdata;
  assign s_rresp  = m_rresp;
  assign s_rlast  = m_rlast;
  assign m_wvalid = s_wvalid;
  assign s_wready = m_wready;
  assign m_wdata  = s_wdata;
  assign m_wstrb  = s_wstrb;
  assign m_wlast  = s_wlast;
  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;
  assign s_bid    = m_bid;
  assign s_bresp  = m_bresp;

endmodule

// File: rtl/gate_chk.sv
module gate_chk
  import axi_gate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int RD_LIMIT  = 1,
  parameter int WR_LIMIT  = 1,
  parameter int TOT_LIMIT = 1
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             s_arvalid,
  input logic                             s_arready,
  input logic                             s_awvalid,
  input logic                             s_awready,
  input logic                             m_arvalid,
  input logic                             m_arready,
  input logic [ADDR_W-1:0]                m_araddr,
  input logic                             m_awvalid,
  input logic                             m_awready,
  input logic [ADDR_W-1:0]                m_awaddr,
  input logic [cnt_width(RD_LIMIT)-1:0]   rd_cnt,
  input logic [cnt_width(WR_LIMIT)-1:0]   wr_cnt,
  input logic [cnt_width(TOT_LIMIT)-1:0]  tot_cnt
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (tot_cnt == '0) && (rd_cnt == '0) && (wr_cnt == '0) && !m_arvalid && !m_awvalid); // R1
  AST_RD_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(rd_cnt) <= RD_LIMIT); // R2
  AST_WR_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(wr_cnt) <= WR_LIMIT); // R3
  AST_TOT_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(tot_cnt) <= TOT_LIMIT); // R4
  AST_TOT_SUM: assert property (@(posedge clk) disable iff (rst)
    int'(tot_cnt) == int'(rd_cnt) + int'(wr_cnt)); // R4
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (int'(tot_cnt) >= TOT_LIMIT) |-> (!s_arready && !s_awready)); // R4
  AST_READ_WINS: assert property (@(posedge clk) disable iff (rst)
    (s_arvalid && s_arready && s_awvalid && (int'(tot_cnt) + 1 >= TOT_LIMIT)) |-> !s_awready); // R5
  AST_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr))); // R8
  AST_AW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr))); // R8

endmodule

bind axi_txn_gate gate_chk #(
  .ADDR_W    (ADDR_W),
  .RD_LIMIT  (RD_LIMIT),
  .WR_LIMIT  (WR_LIMIT),
  .TOT_LIMIT (TOT_LIMIT)
) u_gate_chk (
  .clk       (clk),
  .rst       (rst),
  .s_arvalid (s_arvalid),
  .s_arready (s_arready),
  .s_awvalid (s_awvalid),
  .s_awready (s_awready),
  .m_arvalid (m_arvalid),
  .m_arready (m_arready),
  .m_araddr  (m_araddr),
  .m_awvalid (m_awvalid),
  .m_awready (m_awready),
  .m_awaddr  (m_awaddr),
  .rd_cnt    (rd_cnt),
  .wr_cnt    (wr_cnt),
  .tot_cnt   (tot_cnt)
);

// File: tb/test_axi_txn_gate.sv
`timescale 1ns/1ps
module test_axi_txn_gate;

  localparam int ID_W   = 4;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 8;
  localparam int KEY_W  = ID_W + ADDR_W + LEN_W;

  logic clk = 1'b0;
  logic rst;
  always #2.5 clk = ~clk;

  logic s_arvalid, s_arready; logic [ID_W-1:0] s_arid; logic [ADDR_W-1:0] s_araddr; logic [LEN_W-1:0] s_arlen;
  logic s_rvalid, s_rready; logic [ID_W-1:0] s_rid; logic [DATA_W-1:0] s_rdata; logic [1:0] s_rresp; logic s_rlast;
  logic s_awvalid, s_awready; logic [ID_W-1:0] s_awid; logic [ADDR_W-1:0] s_awaddr; logic [LEN_W-1:0] s_awlen;
  logic s_wvalid, s_wready; logic [DATA_W-1:0] s_wdata; logic [DATA_W/8-1:0] s_wstrb; logic s_wlast;
  logic s_bvalid, s_bready; logic [ID_W-1:0] s_bid; logic [1:0] s_bresp;
  logic m_arvalid, m_arready; logic [ID_W-1:0] m_arid; logic [ADDR_W-1:0] m_araddr; logic [LEN_W-1:0] m_arlen;
  logic m_rvalid, m_rready; logic [ID_W-1:0] m_rid; logic [DATA_W-1:0] m_rdata; logic [1:0] m_rresp; logic m_rlast;
  logic m_awvalid, m_awready; logic [ID_W-1:0] m_awid; logic [ADDR_W-1:0] m_awaddr; logic [LEN_W-1:0] m_awlen;
  logic m_wvalid, m_wready; logic [DATA_W-1:0] m_wdata; logic [DATA_W/8-1:0] m_wstrb; logic m_wlast;
  logic m_bvalid, m_bready; logic [ID_W-1:0] m_bid; logic [1:0] m_bresp;

  axi_txn_gate #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
                 .RD_LIMIT(1), .WR_LIMIT(1), .TOT_LIMIT(1)) i_axi_txn_gate (.*);

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Scoreboards and slave-model job lists
  logic [KEY_W-1:0] exp_ar[$], exp_aw[$];
  logic [ID_W-1:0]  rd_id_q[$], wr_id_q[$];
  logic [LEN_W-1:0] rd_len_q[$];
  int rd_pend = 0, wr_pend = 0, wlast_cnt = 0;
  int out_rd = 0, out_wr = 0;
  bit rd_just = 0, wr_just = 0;
  bit prev_arwait = 0, prev_awwait = 0;
  logic [ADDR_W-1:0] prev_araddr, prev_awaddr;

  // Monitor: samples at the falling edge, before the next rising edge acts.
  always @(negedge clk) begin
    if (!rst) begin
      logic [KEY_W-1:0] e;
      chk((s_rvalid == m_rvalid) && (s_rdata == m_rdata) && (s_rlast == m_rlast) && (s_rid == m_rid)
          && (m_rready == s_rready) && (m_wvalid == s_wvalid) && (m_wdata == s_wdata)
          && (m_wlast == s_wlast) && (s_wready == m_wready) && (s_bvalid == m_bvalid)
          && (s_bid == m_bid) && (m_bready == s_bready), "R9 passthrough", 0, 0);
      if (out_rd + out_wr >= 1)
        chk(!s_arready && !s_awready, "R4 blocked while pending", {s_arready, s_awready}, 0);
      if (s_arvalid && s_awvalid && s_arready)
        chk(!s_awready, "R5 read wins", s_awready, 0);
      if (rd_just) chk(s_arready, "R6 reopen after rlast", s_arready, 1);
      if (wr_just) chk(s_awready == !s_arvalid, "R7 reopen after B", s_awready, !s_arvalid);
      if (prev_arwait) chk(m_arvalid && m_araddr == prev_araddr, "R8 ar hold", m_araddr, prev_araddr);
      if (prev_awwait) chk(m_awvalid && m_awaddr == prev_awaddr, "R8 aw hold", m_awaddr, prev_awaddr);
      if (m_arvalid && m_arready) begin
        e = (exp_ar.size() != 0) ? exp_ar.pop_front() : 'x;
        chk({m_arid, m_araddr, m_arlen} === e, "R8 ar forward", {m_arid, m_araddr, m_arlen}, e);
        rd_id_q.push_back(m_arid); rd_len_q.push_back(m_arlen); rd_pend++;
      end
      if (m_awvalid && m_awready) begin
        e = (exp_aw.size() != 0) ? exp_aw.pop_front() : 'x;
        chk({m_awid, m_awaddr, m_awlen} === e, "R8 aw forward", {m_awid, m_awaddr, m_awlen}, e);
        wr_id_q.push_back(m_awid); wr_pend++;
      end
      if (m_wvalid && m_wready && m_wlast) wlast_cnt++;
      prev_arwait = m_arvalid && !m_arready; prev_araddr = m_araddr;
      prev_awwait = m_awvalid && !m_awready; prev_awaddr = m_awaddr;
      rd_just = m_rvalid && s_rready && m_rlast;
      wr_just = m_bvalid && s_bready;
      out_rd += int'(s_arvalid && s_arready) - int'(rd_just);
      out_wr += int'(s_awvalid && s_awready) - int'(wr_just);
      chk(out_rd <= 1, "R2 read cap", out_rd, 1);
      chk(out_wr <= 1, "R3 write cap", out_wr, 1);
      chk(out_rd + out_wr <= 1, "R4 combined cap", out_rd + out_wr, 1);
    end
  end

  // Random READY stalls on both sides
  initial begin
    m_arready = 0; m_awready = 0; m_wready = 0; s_rready = 0; s_bready = 0;
    forever begin
      @(posedge clk); #1;
      m_arready = ($urandom % 4) != 0;
      m_awready = ($urandom % 4) != 0;
      m_wready  = ($urandom % 3) != 0;
      s_rready  = ($urandom % 3) != 0;
      s_bready  = ($urandom % 3) != 0;
    end
  end

  // Slave read responder
  initial begin
    m_rvalid = 0; m_rlast = 0; m_rid = '0; m_rdata = '0; m_rresp = '0;
    forever begin
      logic [ID_W-1:0] id; logic [LEN_W-1:0] ln;
      wait (rd_pend > 0);
      id = rd_id_q.pop_front(); ln = rd_len_q.pop_front(); rd_pend--;
      for (int b = 0; b <= int'(ln); b++) begin
        @(posedge clk); #1;
        while (($urandom % 4) == 0) begin m_rvalid = 0; @(posedge clk); #1; end
        m_rvalid = 1; m_rid = id; m_rdata = $urandom; m_rlast = (b == int'(ln));
        forever begin @(negedge clk); if (s_rready) break; end
      end
      @(posedge clk); #1; m_rvalid = 0; m_rlast = 0;
    end
  end

  // Slave write responder
  initial begin
    m_bvalid = 0; m_bid = '0; m_bresp = '0;
    forever begin
      wait (wr_pend > 0 && wlast_cnt > 0);
      wr_pend--; wlast_cnt--;
      @(posedge clk); #1;
      while (($urandom % 4) == 0) begin @(posedge clk); #1; end
      m_bvalid = 1; m_bid = wr_id_q.pop_front();
      forever begin @(negedge clk); if (s_bready) break; end
      @(posedge clk); #1; m_bvalid = 0;
    end
  end

  task automatic send_ar(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] ln);
    @(posedge clk); #1;
    s_arvalid = 1; s_arid = id; s_araddr = a; s_arlen = ln;
    forever begin @(negedge clk); if (s_arready) break; end
    exp_ar.push_back({id, a, ln});
    @(posedge clk); #1; s_arvalid = 0;
  endtask

  task automatic send_aw(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] ln);
    @(posedge clk); #1;
    s_awvalid = 1; s_awid = id; s_awaddr = a; s_awlen = ln;
    forever begin @(negedge clk); if (s_awready) break; end
    exp_aw.push_back({id, a, ln});
    @(posedge clk); #1; s_awvalid = 0;
    for (int b = 0; b <= int'(ln); b++) begin
      s_wvalid = 1; s_wdata = $urandom; s_wstrb = '1; s_wlast = (b == int'(ln));
      forever begin @(negedge clk); if (s_wready) break; end
      @(posedge clk); #1;
    end
    s_wvalid = 0; s_wlast = 0;
  endtask

  task automatic send_both(input logic [LEN_W-1:0] rl, input logic [LEN_W-1:0] wl);
    fork
      send_ar(4'h3, $urandom, rl);
      send_aw(4'h5, $urandom, wl);
    join
  endtask

  initial begin
    rst = 1;
    s_arvalid = 0; s_arid = '0; s_araddr = '0; s_arlen = '0;
    s_awvalid = 0; s_awid = '0; s_awaddr = '0; s_awlen = '0;
    s_wvalid = 0; s_wdata = '0; s_wstrb = '0; s_wlast = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!m_arvalid && !m_awvalid, "R1 no valid in reset", {m_arvalid, m_awvalid}, 0);
    @(posedge clk); #1; rst = 0;
    @(negedge clk);
    chk(s_arready && s_awready, "R1 ready after reset", {s_arready, s_awready}, 3);
    chk(!m_arvalid && !m_awvalid, "R1 idle after reset", {m_arvalid, m_awvalid}, 0);
    // Directed: lone read, lone write, simultaneous pair (R5), long burst then write (R6)
    send_ar(4'h1, 32'h1000, 8'd3);
    send_aw(4'h2, 32'h2000, 8'd2);
    send_both(8'd0, 8'd0);
    send_both(8'd7, 8'd1);
    // Random mixed traffic
    for (int i = 0; i < 150; i++) begin
      int k;
      k = $urandom % 3;
      case (k)
        0: send_ar($urandom, $urandom, $urandom % 8);
        1: send_aw($urandom, $urandom, $urandom % 8);
        default: send_both($urandom % 8, $urandom % 8);
      endcase
    end
    while (out_rd + out_wr != 0 || rd_pend != 0 || wr_pend != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(exp_ar.size() == 0 && exp_aw.size() == 0, "R8 all forwarded", exp_ar.size() + exp_aw.size(), 0);
    chk(s_arready && s_awready, "R4 idle reopen", {s_arready, s_awready}, 3);
    finish_run();
  end

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R4 watchdog: actual hang expected completion");
    finish_run();
  end

endmodule